// File: doc/BRIEF.md
# Multi-Row Compute Memory Array

A small bit array of `ROWS` rows by `COLS` columns that computes while it reads. It has one synchronous write port and two independent read row masks, a false-side mask and a true-side mask. When several rows are enabled at once, each column does not return a stored word. Its false-side line settles to the NOR of the cells enabled on the false-side mask. Its true-side line settles to the AND of the cells enabled on the true-side mask. Both lines are modelled as ideal logic: a line that no cell discharges stays high.

A small slice of logic sits below every column. It takes the two lines and an operation code of its own, so neighbouring columns can run different functions in the same cycle. The functions are constants, plain and inverted reads, NOR, OR, AND, NAND, match and mismatch across many rows, implication with mixed terms, and a half-adder or half-subtractor slice whose carry term is chosen by the add-enable flag.

The write port can store either external data or the result bus of the same cycle. This lets a computed word go back into a chosen row with no round trip through another block. Reads are combinational from the stored state, so a read of the row being written returns its old contents.

Top module: `cmem_compute_array`

## Requirements
- R1: While `rst_n` is low, every cell is cleared to 0 on the clock edge.
- R2: A write with `wr_en`=1 and `wr_wb`=0 stores `wr_data` into row `wr_row` at the rising edge. With a single row enabled, `line_t` returns that row and `line_f` returns its inverse.
- R3: Bit c of `line_f` is 1 exactly when no row enabled in `rd_mask_f` holds a 1 in column c. An all-zero mask gives 1.
- R4: Bit c of `line_t` is 1 exactly when every row enabled in `rd_mask_t` holds a 1 in column c. An all-zero mask gives 1.
- R5: Column c takes its code from `op_sel[4c+3:4c]`. Code 4 gives `line_f` (NOR), 5 gives its inverse (OR), 6 gives `line_t` (AND) and 7 gives its inverse (NAND).
- R6: With the same rows on both masks, code 8 gives 1 when all enabled cells of the column agree (XNOR) and code 9 gives 1 when any two differ (XOR/compare), for two or more rows.
- R7: Code 10 gives NOT(`line_f` AND `line_t`). With one row F on the false side and one row T on the true side, this is the implication T → F. With the same rows on both sides it is always 1.
- R8: Code 0 gives 0, code 1 gives 1, code 2 gives `line_t` (read) and code 3 gives `line_f` (read inverted).
- R9: Let A be the single false-side row and B the single true-side row. Code 11 gives A XOR B. Code 12 gives A AND B when `add_en`=1 (carry) and NOT A AND B when `add_en`=0 (borrow). Any code of 13 or above gives 0.
- R10: Different codes in different columns act independently in the same cycle.
- R11: A write and a read of the same row in one cycle return the old contents. The new contents are visible from the next cycle.
- R12: A write with `wr_en`=1 and `wr_wb`=1 stores the current `result` bus into row `wr_row`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_row | input | $clog2(ROWS) | Row written |
| wr_wb | input | 1 | 1: write the result bus, 0: write `wr_data` |
| wr_data | input | COLS | External write data |
| rd_mask_f | input | ROWS | Rows enabled on the false-side lines |
| rd_mask_t | input | ROWS | Rows enabled on the true-side lines |
| op_sel | input | 4*COLS | Per-column operation code |
| add_en | input | 1 | Carry (1) or borrow (0) for code 12 |
| result | output | COLS | Per-column computed result |
| line_f | output | COLS | Raw false-side line per column |
| line_t | output | COLS | Raw true-side line per column |

## Verification
A wrong stored bit shows at the ports in the first cycle in which any mask enables its row. The raw line of that column flips, and so does every derived result that depends on it. No pipeline hides the fault. A fault in the write path, whether wrong row, wrong source or late commit, appears exactly one cycle after the write as a mismatch on a single-row read. For that reason every write in the bench is followed by reads that single out the written row. A slice that decodes the wrong code differs from the expected result in the same cycle, only in its own column.

// File: rtl/cmem_pkg.sv
package cmem_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ZERO   = 4'd0,
    OP_ONE    = 4'd1,
    OP_READ   = 4'd2,
    OP_RINV   = 4'd3,
    OP_NOR    = 4'd4,
    OP_OR     = 4'd5,
    OP_AND    = 4'd6,
    OP_NAND   = 4'd7,
    OP_XNOR   = 4'd8,
    OP_XOR    = 4'd9,
    OP_IMP    = 4'd10,
    OP_HSUM   = 4'd11,
    OP_HCARRY = 4'd12
  } col_op_e;

  // One column slice: lf is the NOR line, lt is the AND line.
  function automatic logic slice_eval(input logic [OP_W-1:0] op,
                                      input logic lf,
                                      input logic lt,
                                      input logic add_en);
    logic r;
    case (op)
      OP_ZERO:   r = 1'b0;
      OP_ONE:    r = 1'b1;
      OP_READ:   r = lt;
      OP_RINV:   r = lf;
      OP_NOR:    r = lf;
      OP_OR:     r = ~lf;
      OP_AND:    r = lt;
      OP_NAND:   r = ~lt;
      OP_XNOR:   r = lf | lt;
      OP_XOR:    r = ~(lf | lt);
      OP_IMP:    r = ~(lf & lt);
      OP_HSUM:   r = ~(lf ^ lt);
      OP_HCARRY: r = add_en ? (~lf & lt) : (lf & lt);
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmem_cell_array.sv
module cmem_cell_array #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic [COLS-1:0]            wr_word,
  output logic [ROWS-1:0][COLS-1:0]  cells
);

  logic [ROWS-1:0][COLS-1:0] store_q;
  logic                      wr_hit;

  assign wr_hit = wr_en && (int'(wr_row) < ROWS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (wr_hit) begin
      store_q[wr_row] <= wr_word;
    end
  end

  assign cells = store_q;

endmodule

// File: rtl/cmem_line_eval.sv
module cmem_line_eval #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic [ROWS-1:0][COLS-1:0]  cells,
  input  logic [ROWS-1:0]            mask_f,
  input  logic [ROWS-1:0]            mask_t,
  output logic [COLS-1:0]            line_f,
  output logic [COLS-1:0]            line_t
);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] column;
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign column[r] = cells[r][c];
    end
    // Discharged by any enabled cell holding 1 on the false side,
    // or any enabled cell holding 0 on the true side.
    assign line_f[c] = ~|(column & mask_f);
    assign line_t[c] = ~|(~column & mask_t);
  end

endmodule

// File: rtl/cmem_slice_alu.sv
module cmem_slice_alu
  import cmem_pkg::*;
#(
  parameter int COLS = 8
) (
  input  logic [COLS-1:0]       line_f,
  input  logic [COLS-1:0]       line_t,
  input  logic [OP_W*COLS-1:0]  op_sel,
  input  logic                  add_en,
  output logic [COLS-1:0]       result
);

  for (genvar c = 0; c < COLS; c++) begin : g_slice
    assign result[c] = slice_eval(op_sel[c*OP_W +: OP_W], line_f[c], line_t[c], add_en);
  end

endmodule

// File: rtl/cmem_compute_array.sv
module cmem_compute_array
  import cmem_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ROW_W-1:0]      wr_row,
  input  logic                  wr_wb,
  input  logic [COLS-1:0]       wr_data,
  input  logic [ROWS-1:0]       rd_mask_f,
  input  logic [ROWS-1:0]       rd_mask_t,
  input  logic [OP_W*COLS-1:0]  op_sel,
  input  logic                  add_en,
  output logic [COLS-1:0]       result,
  output logic [COLS-1:0]       line_f,
  output logic [COLS-1:0]       line_t
);

  logic [ROWS-1:0][COLS-1:0] cells;
  logic [COLS-1:0]           wr_word;

  // Same-cycle write-back takes the live result bus.
  assign wr_word = wr_wb ? result : wr_data;

  cmem_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_word (wr_word),
    .cells   (cells)
  );

  cmem_line_eval #(.ROWS(ROWS), .COLS(COLS)) u_lines (
    .cells  (cells),
    .mask_f (rd_mask_f),
    .mask_t (rd_mask_t),
    .line_f (line_f),
    .line_t (line_t)
  );

  cmem_slice_alu #(.COLS(COLS)) u_alu (
    .line_f (line_f),
    .line_t (line_t),
    .op_sel (op_sel),
    .add_en (add_en),
    .result (result)
  );

endmodule

// File: rtl/cmem_compute_array_chk.sv
module cmem_compute_array_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ROW_W-1:0]  wr_row,
  input logic              wr_wb,
  input logic [COLS-1:0]   wr_data,
  input logic [ROWS-1:0]   rd_mask_f,
  input logic [ROWS-1:0]   rd_mask_t,
  input logic [COLS-1:0]   result,
  input logic [COLS-1:0]   line_f,
  input logic [COLS-1:0]   line_t,
  input logic [COLS-1:0]   wr_word
);

  // R3/R4: unselected lines stay precharged.
  assert_empty_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mask_f == '0) |-> (line_f == {COLS{1'b1}}));

  assert_empty_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mask_t == '0) |-> (line_t == {COLS{1'b1}}));

  // R6/R7: with identical non-empty masks a column cannot be all-0 and all-1.
  assert_dual_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_mask_f == rd_mask_t) && (rd_mask_f != '0)) |-> ((line_f & line_t) == '0));

  // R2: external data is readable from the written row on the next cycle.
  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wb) |=>
      ((rd_mask_t != (ROWS'(1) << $past(wr_row))) || (line_t == $past(wr_data))));

  // R12: the write-back row holds the previous cycle's result.
  assert_writeback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wb) |=>
      ((rd_mask_t != (ROWS'(1) << $past(wr_row))) || (line_t == $past(result))));

  // R11: with no write and steady masks, the lines do not move.
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(rd_mask_f) && $stable(rd_mask_t))
      |-> ($stable(line_f) && $stable(line_t)));

  // R12: the write word follows the selected source.
  assert_wb_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_word == (wr_wb ? result : wr_data)));

endmodule

bind cmem_compute_array cmem_compute_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_row    (wr_row),
  .wr_wb     (wr_wb),
  .wr_data   (wr_data),
  .rd_mask_f (rd_mask_f),
  .rd_mask_t (rd_mask_t),
  .result    (result),
  .line_f    (line_f),
  .line_t    (line_t),
  .wr_word   (wr_word)
);

// File: tb/tb_cmem_compute_array.sv
`timescale 1ns/1ps
module tb_cmem_compute_array;

  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int RW   = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [RW-1:0]   wr_row = '0;
  logic            wr_wb = 1'b0;
  logic [COLS-1:0] wr_data = '0;
  logic [ROWS-1:0] rd_mask_f = '0;
  logic [ROWS-1:0] rd_mask_t = '0;
  logic [4*COLS-1:0] op_sel = '0;
  logic            add_en = 1'b0;
  logic [COLS-1:0] result, line_f, line_t;

  always #2.5 clk = ~clk;

  cmem_compute_array #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_wb(wr_wb),
    .wr_data(wr_data), .rd_mask_f(rd_mask_f), .rd_mask_t(rd_mask_t),
    .op_sel(op_sel), .add_en(add_en), .result(result), .line_f(line_f), .line_t(line_t)
  );

  // Bench model of the array contents.
  logic [COLS-1:0] model [ROWS];

  logic [COLS-1:0] q_res [$];
  logic [COLS-1:0] q_lf  [$];
  logic [COLS-1:0] q_lt  [$];
  string           q_tag [$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic logic [4*COLS-1:0] all_ops(input logic [3:0] code);
    return {COLS{code}};
  endfunction

  function automatic logic op_model(input logic [3:0] code, input logic f, input logic t,
                                    input logic ae);
    // f: 1 when no enabled false-side cell is 1; t: 1 when all true-side cells are 1.
    logic a, b;
    a = ~f; b = t;
    if (code == 4'd0)  return 1'b0;
    if (code == 4'd1)  return 1'b1;
    if (code == 4'd2)  return t;
    if (code == 4'd3)  return f;
    if (code == 4'd4)  return f;
    if (code == 4'd5)  return !f;
    if (code == 4'd6)  return t;
    if (code == 4'd7)  return !t;
    if (code == 4'd8)  return (f || t);
    if (code == 4'd9)  return !(f || t);
    if (code == 4'd10) return (!f || !t);
    if (code == 4'd11) return a != b;
    if (code == 4'd12) return ae ? (a && b) : (!a && b);
    return 1'b0;
  endfunction

  task automatic step(input logic we, input int row, input logic wb, input logic [COLS-1:0] data,
                      input logic [ROWS-1:0] mf, input logic [ROWS-1:0] mt,
                      input logic [4*COLS-1:0] ops, input logic ae, input string tag);
    logic [COLS-1:0] ef, et, er;
    @(negedge clk);
    wr_en = we; wr_row = RW'(row); wr_wb = wb; wr_data = data;
    rd_mask_f = mf; rd_mask_t = mt; op_sel = ops; add_en = ae;
    for (int c = 0; c < COLS; c++) begin
      ef[c] = 1'b1; et[c] = 1'b1;
      for (int r = 0; r < ROWS; r++) begin
        if (mf[r] && model[r][c])  ef[c] = 1'b0;
        if (mt[r] && !model[r][c]) et[c] = 1'b0;
      end
      er[c] = op_model(ops[4*c +: 4], ef[c], et[c], ae);
    end
    q_res.push_back(er); q_lf.push_back(ef); q_lt.push_back(et); q_tag.push_back(tag);
    if (we) model[row] = wb ? er : data;
  endtask

  // Monitor: compares one scoreboard entry per cycle, away from the edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_res.size() > 0) begin
        logic [COLS-1:0] er, ef, et;
        string tg;
        er = q_res.pop_front(); ef = q_lf.pop_front(); et = q_lt.pop_front();
        tg = q_tag.pop_front();
        checks++;
        if (result !== er || line_f !== ef || line_t !== et) begin
          fails++;
          $display("FAIL %s: got res=%h lf=%h lt=%h expected res=%h lf=%h lt=%h",
                   tg, result, line_f, line_t, er, ef, et);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared contents.
    step(0, 0, 0, '0, '1, '1, all_ops(4'd4), 0, "R1 reset clear");

    // R2: load rows, masks empty so R3/R4 precharge is also seen.
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] v;
      v = COLS'(8'h3C ^ (r * 8'h27) ^ (r << 5));
      step(1, r, 0, v, '0, '0, all_ops(4'd0), 0, "R3 R4 empty mask during write");
    end
    step(1, 3, 0, 8'h00, '0, '0, all_ops(4'd1), 0, "R8 const one");
    step(1, 2, 0, 8'hFF, '0, '0, all_ops(4'd1), 0, "R8 const one");
    for (int r = 0; r < ROWS; r++) begin
      step(0, 0, 0, '0, ROWS'(1) << r, ROWS'(1) << r, all_ops(4'd2), 0, "R2 single row read");
      step(0, 0, 0, '0, ROWS'(1) << r, '0, all_ops(4'd3), 0, "R8 read inverted");
    end

    // R3/R4/R5 multi-row.
    step(0, 0, 0, '0, 8'b0000_0111, 8'b0000_0111, all_ops(4'd4), 0, "R3 R5 nor three rows");
    step(0, 0, 0, '0, 8'b0011_0000, 8'b1100_0001, all_ops(4'd5), 0, "R5 or");
    step(0, 0, 0, '0, 8'b0000_0000, 8'b0101_0101, all_ops(4'd6), 0, "R4 R5 and");
    step(0, 0, 0, '0, 8'b1111_1111, 8'b1111_1011, all_ops(4'd7), 0, "R5 nand");

    // R6 match / mismatch.
    step(0, 0, 0, '0, 8'b0000_0011, 8'b0000_0011, all_ops(4'd9), 0, "R6 xor two rows");
    step(0, 0, 0, '0, 8'b0000_0011, 8'b0000_0011, all_ops(4'd8), 0, "R6 xnor two rows");
    step(0, 0, 0, '0, 8'b1011_0100, 8'b1011_0100, all_ops(4'd9), 0, "R6 compare four rows");
    step(0, 0, 0, '0, 8'b1011_0100, 8'b1011_0100, all_ops(4'd8), 0, "R6 match four rows");

    // R7 implication and mixed.
    step(0, 0, 0, '0, 8'b0000_0001, 8'b0000_0010, all_ops(4'd10), 0, "R7 implication");
    step(0, 0, 0, '0, 8'b0000_0110, 8'b0101_0000, all_ops(4'd10), 0, "R7 mixed");
    step(0, 0, 0, '0, 8'b0001_1000, 8'b0001_1000, all_ops(4'd10), 0, "R7 dual always one");

    // R8 constants.
    step(0, 0, 0, '0, 8'hFF, 8'hFF, all_ops(4'd0), 0, "R8 const zero");

    // R9 half add / subtract.
    step(0, 0, 0, '0, 8'b0000_0001, 8'b0001_0000, all_ops(4'd11), 0, "R9 half sum");
    step(0, 0, 0, '0, 8'b0000_0001, 8'b0001_0000, all_ops(4'd12), 1, "R9 carry");
    step(0, 0, 0, '0, 8'b0000_0001, 8'b0001_0000, all_ops(4'd12), 0, "R9 borrow");
    step(0, 0, 0, '0, 8'b0000_0101, 8'b0000_0110, all_ops(4'd13), 1, "R9 unused code");

    // R10 per-column operation mix.
    step(0, 0, 0, '0, 8'b0000_0011, 8'b0000_0011,
         {4'd12, 4'd11, 4'd10, 4'd9, 4'd8, 4'd7, 4'd5, 4'd1}, 1, "R10 mixed columns");
    step(0, 0, 0, '0, 8'b0100_0001, 8'b0010_0000,
         {4'd0, 4'd2, 4'd3, 4'd4, 4'd6, 4'd10, 4'd11, 4'd12}, 0, "R10 mixed columns");

    // R11 same-row write and read.
    step(1, 4, 0, 8'h96, 8'b0001_0000, 8'b0001_0000, all_ops(4'd2), 0, "R11 old contents");
    step(0, 0, 0, '0, 8'b0001_0000, 8'b0001_0000, all_ops(4'd2), 0, "R11 new contents");

    // R12 write-back.
    step(1, 7, 1, 8'hAA, 8'b0000_0011, 8'b0000_0011, all_ops(4'd9), 0, "R12 write-back source");
    step(0, 0, 0, '0, 8'b1000_0000, 8'b1000_0000, all_ops(4'd2), 0, "R12 written result");
    step(1, 6, 1, 8'h55, 8'b1000_0000, 8'b0000_0100, all_ops(4'd11), 0, "R12 sum back");
    step(0, 0, 0, '0, 8'b0100_0000, 8'b0100_0000, all_ops(4'd2), 0, "R12 written sum");

    // R1 again: reset mid-run clears everything.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    step(0, 0, 0, '0, '1, '1, all_ops(4'd5), 0, "R1 reset mid-run");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule